// File: doc/BRIEF.md
# Folded Weight Memory Sequencer

This block feeds a folded matrix-vector engine with its weights. The engine has `PE` processing elements, each with `SIMD` multiply lanes. The weight matrix has `OCH` rows and `KDIM*KDIM*ICH` columns. Rows are dealt out across the PEs in turn: PE `p` owns rows `p`, `p+PE`, `p+2*PE` and so on. Each PE keeps its own rows in a private read-only memory holding `NCOLF*NGRP` words. Here `NCOLF = KDIM*KDIM*ICH/SIMD` is the number of column folds and `NGRP = OCH/PE` is the number of row groups. Each word is `SIMD*WBITS` bits wide.

All PE memories share one read address, and it moves in fold-major order. The address steps through every column fold of a row group before moving to the next group. After the last fold of the last group it returns to zero, ready for the next input vector. The stream controller drives a stall-free compute enable. Each cycle in which that enable is high reads one word from every memory and steps the address forward. The read words appear on the outputs one cycle later, together with a valid flag, the row group and fold they came from, a marker for the last fold, and a marker for the end of the vector.

The sequencing is a three-state machine:
- `ST_IDLE` is the state after reset, before any word has been read.
- `ST_ISSUE` means a word was read in the previous cycle, so the outputs are valid.
- `ST_HOLD` means the outputs still carry the last word, but the datapath is stalled.

The transitions are:
- IDLE→ISSUE and HOLD→ISSUE on enable.
- ISSUE→ISSUE on enable.
- ISSUE→HOLD on no enable.
- IDLE→IDLE and HOLD→HOLD on no enable.

Top module: `fold_weight_seq`

## Requirements
- R1: While and right after reset, `w_valid` is 0 and `w_group`, `w_fold` and `w_data` are 0. The first enabled step after reset reads group 0, fold 0.
- R2: A cycle with `step_en` low does not move the address. In the following cycle `w_valid` is 0, and `w_data`, `w_group`, `w_fold`, `w_last_fold` and `w_vec_end` keep their previous values.
- R3: Each cycle with `step_en` high produces `w_valid` high in the next cycle, carrying the word for that step.
- R4: Successive steps visit fold 0 through NCOLF-1 of a row group, then fold 0 of the next row group.
- R5: The step after group NGRP-1, fold NCOLF-1 returns to group 0, fold 0.
- R6: `w_last_fold` is 1 exactly when the delivered word is from fold NCOLF-1.
- R7: `w_vec_end` is 1 exactly when the delivered word is from fold NCOLF-1 of group NGRP-1.
- R8: For group g and fold f, `w_data` contains one slice per PE. PE `p` occupies bits starting at `p*SIMD*WBITS`. Within that slice, lane `s` occupies the `WBITS` bits starting at `s*WBITS` and holds the weight of row `g*PE+p`, column `f*SIMD+s`. The weight of row r, column c is `(3*r + 5*c + SEED) mod 2^WBITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Stall-free compute enable; one weight step per high cycle |
| w_valid | output | 1 | Weight word for the previous step is present |
| w_data | output | PE*SIMD*WBITS | Weight slices of all PEs, PE 0 in the low bits |
| w_group | output | GW | Row group of the delivered word |
| w_fold | output | FW | Column fold of the delivered word |
| w_last_fold | output | 1 | Delivered word is the final column fold of its row group |
| w_vec_end | output | 1 | Delivered word is the final word of the input vector |

## Verification
The properties assume that `step_en` is a clean level sampled once per clock. They also assume that the parameters divide evenly: `SIMD` divides `KDIM*KDIM*ICH`, and `PE` divides `OCH`. The properties allow any pattern of stalls.

The stimulus changes `step_en` only on falling edges and holds reset low from time zero. It drives three instances that share one enable but differ in their PE/SIMD ratios and word widths. It uses three enable patterns: an unbroken run, a regular stall cadence, and a pseudo-random pattern. Each pattern runs long enough that every instance wraps past the end of its vector at least once.

// File: rtl/fwseq_pkg.sv
package fwseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } seq_state_e;

    // bits needed to count 0..n-1, at least one
    function automatic int unsigned bits_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // fixed weight contents of the matrix: row r, column c
    function automatic int unsigned weight_at(input int unsigned row,
                                              input int unsigned col,
                                              input int unsigned seed,
                                              input int unsigned wbits);
        return (3 * row + 5 * col + seed) % (1 << wbits);
    endfunction

endpackage

// File: rtl/fwseq_ctrl.sv
module fwseq_ctrl
    import fwseq_pkg::*;
#(
    parameter int NCOLF = 9,
    parameter int NGRP  = 4,
    parameter int AW    = 6,
    parameter int FW    = 4,
    parameter int GW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid,
    output logic [FW-1:0] mark_fold,
    output logic [GW-1:0] mark_group,
    output logic          mark_last_fold,
    output logic          mark_vec_end
);

    localparam int DEPTH = NCOLF * NGRP;
    localparam logic [FW-1:0] LAST_F = FW'(NCOLF - 1);
    localparam logic [GW-1:0] LAST_G = GW'(NGRP - 1);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    seq_state_e state, state_nx;

    logic [FW-1:0] fold_q;
    logic [GW-1:0] group_q;
    logic [AW-1:0] addr_q;
    logic          at_last_fold;
    logic          at_last_group;

    assign at_last_fold  = (fold_q == LAST_F);
    assign at_last_group = (group_q == LAST_G);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = step_en ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_nx = step_en ? ST_ISSUE : ST_HOLD;
            ST_HOLD:  state_nx = step_en ? ST_ISSUE : ST_HOLD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en     = step_en;
        out_valid = (state == ST_ISSUE);
        rd_addr   = addr_q;
    end

    // fold-major position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fold_q  <= '0;
            group_q <= '0;
            addr_q  <= '0;
        end else if (step_en) begin
            if (at_last_fold) begin
                fold_q  <= '0;
                group_q <= at_last_group ? '0 : group_q + 1'b1;
            end else begin
                fold_q  <= fold_q + 1'b1;
            end
            addr_q <= (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
        end
    end

    // position markers travel with the memory read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_fold      <= '0;
            mark_group     <= '0;
            mark_last_fold <= 1'b0;
            mark_vec_end   <= 1'b0;
        end else if (step_en) begin
            mark_fold      <= fold_q;
            mark_group     <= group_q;
            mark_last_fold <= at_last_fold;
            mark_vec_end   <= at_last_fold && at_last_group;
        end
    end

    p_hold_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(addr_q));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && addr_q == LAST_A) |=> (addr_q == '0 && fold_q == '0 && group_q == '0));

    p_fold_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fold_q) < NCOLF);

    p_group_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && at_last_fold) |=> (fold_q == '0));

    p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_q) == int'(group_q) * NCOLF + int'(fold_q));

    p_vec_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mark_vec_end |-> mark_last_fold);

endmodule

// File: rtl/fwseq_pe_rom.sv
module fwseq_pe_rom
    import fwseq_pkg::*;
#(
    parameter int PE_IDX = 0,
    parameter int PE     = 2,
    parameter int SIMD   = 4,
    parameter int WBITS  = 4,
    parameter int NCOLF  = 9,
    parameter int DEPTH  = 36,
    parameter int SEED   = 1,
    parameter int AW     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [AW-1:0]         rd_addr,
    output logic [SIMD*WBITS-1:0] rd_word
);

    localparam int WW = SIMD * WBITS;

    logic [DEPTH-1:0][WW-1:0] mem;

    // word a holds row group a/NCOLF, fold a%NCOLF of this PE's rows
    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        for (genvar s = 0; s < SIMD; s++) begin : g_lane
            assign mem[a][s*WBITS +: WBITS] = WBITS'(weight_at(
                (a / NCOLF) * PE + PE_IDX,
                (a % NCOLF) * SIMD + s,
                SEED, WBITS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_word <= '0;
        else if (rd_en) rd_word <= mem[rd_addr];
    end

    p_addr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < DEPTH));

endmodule

// File: rtl/fold_weight_seq.sv
module fold_weight_seq
    import fwseq_pkg::*;
#(
    parameter int PE    = 2,
    parameter int SIMD  = 4,
    parameter int WBITS = 4,
    parameter int KDIM  = 3,
    parameter int ICH   = 4,
    parameter int OCH   = 8,
    parameter int SEED  = 1,
    localparam int NCOLF = (KDIM * KDIM * ICH) / SIMD,
    localparam int NGRP  = OCH / PE,
    localparam int FW    = bits_for(NCOLF),
    localparam int GW    = bits_for(NGRP),
    localparam int DW    = PE * SIMD * WBITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    output logic          w_valid,
    output logic [DW-1:0] w_data,
    output logic [GW-1:0] w_group,
    output logic [FW-1:0] w_fold,
    output logic          w_last_fold,
    output logic          w_vec_end
);

    localparam int DEPTH = NCOLF * NGRP;
    localparam int AW    = bits_for(DEPTH);
    localparam int WW    = SIMD * WBITS;

    logic          rd_en;
    logic [AW-1:0] rd_addr;

    fwseq_ctrl #(
        .NCOLF(NCOLF), .NGRP(NGRP), .AW(AW), .FW(FW), .GW(GW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .out_valid(w_valid),
        .mark_fold(w_fold), .mark_group(w_group),
        .mark_last_fold(w_last_fold), .mark_vec_end(w_vec_end)
    );

    for (genvar p = 0; p < PE; p++) begin : g_pe
        fwseq_pe_rom #(
            .PE_IDX(p), .PE(PE), .SIMD(SIMD), .WBITS(WBITS),
            .NCOLF(NCOLF), .DEPTH(DEPTH), .SEED(SEED), .AW(AW)
        ) u_rom (
            .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
            .rd_word(w_data[p*WW +: WW])
        );
    end

    p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> w_valid);

    p_stall_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> (!w_valid && $stable(w_data) && $stable(w_fold) && $stable(w_group)));

    p_last_marker_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> (w_last_fold == (int'(w_fold) == NCOLF - 1)));

endmodule

// File: tb/sim_fold_weight_seq.sv
module sim_fold_weight_seq;

    typedef struct {
        logic [63:0] data;
        int          grp;
        int          fold;
        bit          lastf;
        bit          vend;
        bit          wrap;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // instance 0: PE2 SIMD4 W4, 3x3x4 -> 8 rows : 9 folds, 4 groups
    logic        v0, lf0, ve0;
    logic [31:0] d0;
    logic [1:0]  g0;
    logic [3:0]  f0;
    fold_weight_seq #(.PE(2), .SIMD(4), .WBITS(4), .KDIM(3), .ICH(4), .OCH(8), .SEED(1)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .w_valid(v0), .w_data(d0),
        .w_group(g0), .w_fold(f0), .w_last_fold(lf0), .w_vec_end(ve0));

    // instance 1: PE4 SIMD2 W3, 1x1x6 -> 8 rows : 3 folds, 2 groups
    logic        v1, lf1, ve1;
    logic [23:0] d1;
    logic [0:0]  g1;
    logic [1:0]  f1;
    fold_weight_seq #(.PE(4), .SIMD(2), .WBITS(3), .KDIM(1), .ICH(6), .OCH(8), .SEED(2)) u1 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .w_valid(v1), .w_data(d1),
        .w_group(g1), .w_fold(f1), .w_last_fold(lf1), .w_vec_end(ve1));

    // instance 2: PE1 SIMD1 W2, 2x2x1 -> 3 rows : 4 folds, 3 groups
    logic        v2, lf2, ve2;
    logic [1:0]  d2;
    logic [1:0]  g2;
    logic [1:0]  f2;
    fold_weight_seq #(.PE(1), .SIMD(1), .WBITS(2), .KDIM(2), .ICH(1), .OCH(3), .SEED(0)) u2 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .w_valid(v2), .w_data(d2),
        .w_group(g2), .w_fold(f2), .w_last_fold(lf2), .w_vec_end(ve2));

    exp_t q0[$], q1[$], q2[$];
    exp_t last0, last1, last2;
    int n0 = 0, n1 = 0, n2 = 0;

    function automatic exp_t model(int idx, int pe, int simd, int wb, int ncolf,
                                   int ngrp, int seed);
        exp_t e;
        int a, row, col, val;
        a = idx % (ncolf * ngrp);
        e.grp   = a / ncolf;
        e.fold  = a % ncolf;
        e.lastf = (e.fold == ncolf - 1);
        e.vend  = e.lastf && (e.grp == ngrp - 1);
        e.wrap  = (a == 0) && (idx > 0);
        e.data  = '0;
        for (int p = 0; p < pe; p++) begin
            for (int s = 0; s < simd; s++) begin
                row = e.grp * pe + p;
                col = e.fold * simd + s;
                val = (3 * row + 5 * col + seed) % (1 << wb);
                for (int b = 0; b < wb; b++)
                    e.data[(p * simd + s) * wb + b] = val[b];
            end
        end
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one enable decision per cycle, expected items pushed on accept
    task automatic step(bit e);
        @(negedge clk);
        step_en = e;
        if (e) begin
            q0.push_back(model(n0, 2, 4, 4, 9, 4, 1)); n0++;
            q1.push_back(model(n1, 4, 2, 3, 3, 2, 2)); n1++;
            q2.push_back(model(n2, 1, 1, 2, 4, 3, 0)); n2++;
        end
    endtask

    task automatic compare(string id, bit have, exp_t e, exp_t prev, logic v,
                           logic [63:0] d, int g, int f, logic lf, logic ve);
        if (have) begin
            check(v == 1'b1, "R3", {id, " valid after step"}, v, 1);
            check(d == e.data, "R8", {id, " weight word"}, d, e.data);
            if (e.wrap)
                check(g == 0 && f == 0, "R5", {id, " wrap to start"}, g * 256 + f, 0);
            else
                check(g == e.grp && f == e.fold, "R4", {id, " group/fold"},
                      g * 256 + f, e.grp * 256 + e.fold);
            check(lf == e.lastf, "R6", {id, " last fold marker"}, lf, e.lastf);
            check(ve == e.vend, "R7", {id, " vector end marker"}, ve, e.vend);
        end else begin
            check(v == 1'b0, "R2", {id, " valid low on stall"}, v, 0);
            check(d == prev.data && g == prev.grp && f == prev.fold && lf == prev.lastf
                  && ve == prev.vend, "R2", {id, " outputs held on stall"}, d, prev.data);
        end
    endtask

    // monitor: sample just after each rising edge
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            bit h0, h1, h2;
            exp_t e0, e1, e2;
            h0 = q0.size() > 0;
            h1 = q1.size() > 0;
            h2 = q2.size() > 0;
            if (h0) e0 = q0.pop_front(); else e0 = last0;
            if (h1) e1 = q1.pop_front(); else e1 = last1;
            if (h2) e2 = q2.pop_front(); else e2 = last2;
            compare("u0", h0, e0, last0, v0, 64'(d0), int'(g0), int'(f0), lf0, ve0);
            compare("u1", h1, e1, last1, v1, 64'(d1), int'(g1), int'(f1), lf1, ve1);
            compare("u2", h2, e2, last2, v2, 64'(d2), int'(g2), int'(f2), lf2, ve2);
            if (h0) last0 = e0;
            if (h1) last1 = e1;
            if (h2) last2 = e2;
            check(q0.size() == 0, "R3", "u0 one word per step", q0.size(), 0);
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(v0 == 0 && v1 == 0 && v2 == 0, "R1", "valid in reset", {v0, v1, v2}, 0);
        check(d0 == 0 && g0 == 0 && f0 == 0, "R1", "u0 outputs in reset", d0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(v0 == 0 && v1 == 0 && v2 == 0, "R1", "valid after reset", {v0, v1, v2}, 0);
        last0 = model(0, 2, 4, 4, 9, 4, 1); last0.data = '0; last0.lastf = 0; last0.vend = 0;
        last1 = model(0, 4, 2, 3, 3, 2, 2); last1.data = '0; last1.lastf = 0; last1.vend = 0;
        last2 = model(0, 1, 1, 2, 4, 3, 0); last2.data = '0; last2.lastf = 0; last2.vend = 0;
        mon_on = 1'b1;
        // R1: first step reads group 0 fold 0, checked by monitor (R4 path)
        for (int i = 0; i < 41; i++) step(1'b1);
        step(1'b0);
        step(1'b0);
        for (int i = 0; i < 90; i++) step(i % 3 != 2);
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[2]);
        end
        step(1'b0);
        step(1'b0);
        @(negedge clk);
        mon_on = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule